// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds the joint translation buffer of a processor's memory unit: a set-associative array of tag words and data words (128 sets by 2 ways by default). Software drives it through four plain registers. The tag register holds the virtual page, address-space identifier and valid flag. The data register holds the frame number and permissions. The slot register holds an entry number or a result code. The last register is the command register.

Software loads the descriptor registers and then writes a command code. A probe searches the set that the virtual page selects. It reports a single hit, a miss or a duplicate hit through the slot register. A slot request picks a place for a new entry. A write installs the descriptors at the slot and may ask the smaller translation buffers next to the core to discard their contents. A read brings an entry back into the descriptor registers. A separate command raises only that discard pulse.

Every command occupies the engine for one cycle after it is accepted. While the engine is busy, no register write of any kind is taken. Outside the command, the descriptor and slot registers read back exactly what software last wrote.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset, busy and the discard pulse are low, the tag, data and slot registers read 0, and every entry is invalid, so any probe misses.
- R2: With busy low, a write with select 0, 1 or 2 loads the tag, data or slot register, and the new value is visible from the next cycle. Select 3 issues a command from data bits [2:0].
- R3: An accepted command raises busy for exactly one cycle, and the command takes effect at the end of that cycle. Every register write presented while busy is high, including a command, is ignored.
- R4: Probe (code 1) selects the set from tag bits [19:13]. An entry matches when its valid bit (bit 8) is set, its bits [31:13] equal the tag register's, and its bits [7:0] (the identifier) are equal. On exactly one match, the slot register receives set*WAYS+way with bits 31:30 clear.
- R5: A probe with no matching way loads the slot register with 0x8000_0000 (lookup error, bit 31).
- R6: A probe that matches more than one way of the set loads 0xC000_0000 (bits 31 and 30). Installing duplicate entries is accepted without complaint.
- R7: Get-slot (code 2) loads set*WAYS+way for the lowest-numbered invalid way of the set selected by the tag register.
- R8: When all ways of the set are valid, get-slot returns the way named by a per-set round-robin pointer. The pointer starts at way 0 after reset, advances by one on each such use, and is independent for each set.
- R9: Write (code 3) stores the tag and data registers at the entry named by the slot register's low bits and raises the discard pulse for one cycle. Storing a tag with bit 8 clear invalidates the entry.
- R10: Write-quiet (code 4) stores the entry exactly like code 3 but leaves the discard pulse low.
- R11: Discard (code 5 is read, code 6 is discard): code 6 raises the discard pulse for one cycle and changes neither the registers nor the stored entries.
- R12: Read (code 5) loads the tag and data registers from the entry named by the slot register and leaves the slot register unchanged.
- R13: Codes 0 and 7 occupy the busy cycle but change no register, no entry and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 tag, 1 data, 2 slot, 3 command |
| reg_wdata | input | 32 | Write data |
| tag_q | output | 32 | Tag register contents |
| data_q | output | 32 | Data register contents |
| slot_q | output | 32 | Slot register contents or result code |
| busy | output | 1 | Command in progress |
| utlb_discard | output | 1 | One-cycle request to flush the micro translation buffers |

## Verification
Two activities can land on the same clock edge: the execution of a pending command, and a software write to a register that the command also updates. The bench provokes this in two ways. It writes the tag register, and separately issues a discard command, in the very cycle that a probe executes. It then judges by readback: the tag register must still hold the old value, the slot register must hold the probe result, and no discard pulse may follow. The other contention is inside get-slot, where the invalid-way search and the round-robin pointer compete for the same set. The bench fills whole sets and then invalidates one way, and computes the expected slot arithmetically from set and way.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROBE   = 3'd1,
    OP_GETSLOT = 3'd2,
    OP_WRITE   = 3'd3,
    OP_WRITE_Q = 3'd4,
    OP_READ    = 3'd5,
    OP_DISCARD = 3'd6,
    OP_RSVD    = 3'd7
  } tlbe_op_e;

  localparam logic [1:0] SEL_TAG  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_SLOT = 2'd2;
  localparam logic [1:0] SEL_CMD  = 2'd3;

  localparam int ERR_BIT = 31;
  localparam int DUP_BIT = 30;
endpackage

// File: rtl/tlbe_way_match.sv
module tlbe_way_match #(
  parameter int WAYS       = 2,
  parameter int PAGE_SHIFT = 13,
  parameter int ID_W       = 8,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [31:0]      way_tag [WAYS],
  input  logic [31:0]      probe_tag,
  output logic             hit_any,
  output logic             hit_multi,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAYS-1:0]  free_ways
);
  localparam int VALID_BIT = ID_W;
  localparam logic [31:0] CMP_MASK = ({32{1'b1}} << PAGE_SHIFT) | ((32'd1 << ID_W) - 32'd1);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w]   = way_tag[w][VALID_BIT] && (((way_tag[w] ^ probe_tag) & CMP_MASK) == 32'd0);
    assign free_ways[w] = !way_tag[w][VALID_BIT];
  end

  always_comb begin
    int unsigned cnt;
    cnt     = 0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
        cnt     = cnt + 1;
      end
    end
    hit_any   = (cnt != 0);
    hit_multi = (cnt > 1);
  end
endmodule

// File: rtl/tlbe_victim.sv
module tlbe_victim #(
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAYS-1:0]  free_ways,
  input  logic             advance,
  output logic [WAY_W-1:0] pick
);
  logic [WAY_W-1:0] rr_ptr [SETS];

  always_comb begin
    pick = rr_ptr[set_idx];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free_ways[w]) pick = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
    end else if (advance && (free_ways == '0)) begin
      rr_ptr[set_idx] <= rr_ptr[set_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
  import tlbe_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WAYS       = 2,
  parameter int PAGE_SHIFT = 13,
  parameter int ID_W       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] tag_q,
  output logic [31:0] data_q,
  output logic [31:0] slot_q,
  output logic        busy,
  output logic        utlb_discard
);
  localparam int ENTRIES = SETS * WAYS;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int IDX_W   = SET_W + WAY_W;
  localparam logic [31:0] MISS_CODE = 32'd1 << ERR_BIT;
  localparam logic [31:0] DUP_CODE  = (32'd1 << ERR_BIT) | (32'd1 << DUP_BIT);

  logic [31:0] tag_r, data_r, slot_r;
  logic        busy_r, disc_r;
  tlbe_op_e    op_r;
  logic [31:0] tag_mem [ENTRIES];
  logic [31:0] dat_mem [ENTRIES];

  logic [SET_W-1:0] set_idx;
  logic [IDX_W-1:0] set_base, entry;
  logic [31:0]      set_tags [WAYS];
  logic             hit_any, hit_multi;
  logic [WAY_W-1:0] hit_way, pick_way;
  logic [WAYS-1:0]  free_ways;
  logic             rr_advance;

  assign set_idx  = tag_r[PAGE_SHIFT +: SET_W];
  assign set_base = IDX_W'(set_idx) << WAY_W;
  assign entry    = slot_r[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_set_rd
    assign set_tags[w] = tag_mem[set_base | IDX_W'(w)];
  end

  tlbe_way_match #(.WAYS(WAYS), .PAGE_SHIFT(PAGE_SHIFT), .ID_W(ID_W)) match_i (
    .way_tag   (set_tags),
    .probe_tag (tag_r),
    .hit_any   (hit_any),
    .hit_multi (hit_multi),
    .hit_way   (hit_way),
    .free_ways (free_ways)
  );

  assign rr_advance = busy_r && (op_r == OP_GETSLOT);

  tlbe_victim #(.SETS(SETS), .WAYS(WAYS)) victim_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_idx   (set_idx),
    .free_ways (free_ways),
    .advance   (rr_advance),
    .pick      (pick_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_r  <= '0;
      data_r <= '0;
      slot_r <= '0;
      busy_r <= 1'b0;
      disc_r <= 1'b0;
      op_r   <= OP_NONE;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_mem[i] <= '0;
        dat_mem[i] <= '0;
      end
    end else begin
      disc_r <= 1'b0;
      if (busy_r) begin
        busy_r <= 1'b0;
        case (op_r)
          OP_PROBE: begin
            if (!hit_any)      slot_r <= MISS_CODE;
            else if (hit_multi) slot_r <= DUP_CODE;
            else               slot_r <= 32'(set_base | IDX_W'(hit_way));
          end
          OP_GETSLOT: slot_r <= 32'(set_base | IDX_W'(pick_way));
          OP_WRITE, OP_WRITE_Q: begin
            tag_mem[entry] <= tag_r;
            dat_mem[entry] <= data_r;
            disc_r         <= (op_r == OP_WRITE);
          end
          OP_READ: begin
            tag_r  <= tag_mem[entry];
            data_r <= dat_mem[entry];
          end
          OP_DISCARD: disc_r <= 1'b1;
          default: ;
        endcase
      end else if (reg_we) begin
        case (reg_sel)
          SEL_TAG:  tag_r  <= reg_wdata;
          SEL_DATA: data_r <= reg_wdata;
          SEL_SLOT: slot_r <= reg_wdata;
          default: begin
            busy_r <= 1'b1;
            op_r   <= tlbe_op_e'(reg_wdata[2:0]);
          end
        endcase
      end
    end
  end

  assign tag_q        = tag_r;
  assign data_q       = data_r;
  assign slot_q       = slot_r;
  assign busy         = busy_r;
  assign utlb_discard = disc_r;
endmodule

// File: rtl/tlb_cmd_engine_chk.sv
module tlb_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        busy,
  input logic        utlb_discard,
  input logic [31:0] tag_q,
  input logic [31:0] data_q,
  input logic [31:0] slot_q
);
  p_busy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_discard_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_discard |=> !utlb_discard);

  p_discard_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(utlb_discard) |-> $past(busy));

  p_dup_has_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[30] |-> slot_q[31]);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_we) |=> ($stable(tag_q) && $stable(data_q) && $stable(slot_q)));
endmodule

bind tlb_cmd_engine tlb_cmd_engine_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .busy         (busy),
  .utlb_discard (utlb_discard),
  .tag_q        (tag_q),
  .data_q       (data_q),
  .slot_q       (slot_q)
);

// File: tb/tlb_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module tlb_cmd_engine_tb_top;
  localparam int SETS = 128;
  localparam int WAYS = 2;
  localparam logic [31:0] MISS = 32'h8000_0000;
  localparam logic [31:0] DUP  = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] tag_q, data_q, slot_q;
  logic        busy, utlb_discard;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tlb_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .tag_q(tag_q), .data_q(data_q), .slot_q(slot_q),
    .busy(busy), .utlb_discard(utlb_discard)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // returns with the command executed; disc = pulse seen after execute edge
  task automatic cmd(input logic [2:0] code, output logic disc, output logic bsy);
    wr(2'd3, {29'd0, code});
    bsy = busy;
    @(negedge clk);
    disc = utlb_discard;
  endtask

  function automatic logic [31:0] mk_tag(input int s, input int hi, input int id, input bit v);
    return (32'(hi) << 20) | (32'(s) << 13) | (32'(v) << 8) | 32'(id & 8'hFF);
  endfunction

  function automatic logic [31:0] mk_dat(input int s, input int w);
    return 32'hA000_0000 | (32'(s) << 8) | 32'(w);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic d, b;
    logic [31:0] t_old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tag", tag_q, 32'd0);
    check("R1 data", data_q, 32'd0);
    check("R1 slot", slot_q, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 discard", {31'd0, utlb_discard}, 32'd0);
    wr(2'd0, mk_tag(0, 1, 0, 1'b1));
    cmd(3'd1, d, b);
    check("R1 probe after reset misses", slot_q, MISS);

    // R2 readback
    wr(2'd0, 32'h1234_5678); check("R2 tag write", tag_q, 32'h1234_5678);
    wr(2'd1, 32'h9ABC_DEF0); check("R2 data write", data_q, 32'h9ABC_DEF0);
    wr(2'd2, 32'h0000_0042); check("R2 slot write", slot_q, 32'h0000_0042);

    // Fill every entry: probe miss, get-slot first free, write
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        wr(2'd0, mk_tag(s, w + 1, s + w, 1'b1));
        cmd(3'd1, d, b);
        check("R5 probe miss before install", slot_q, MISS);
        cmd(3'd2, d, b);
        check("R7 first free way", slot_q, 32'(s * WAYS + w));
        wr(2'd1, mk_dat(s, w));
        cmd(3'd3, d, b);
        check("R3 busy during command", {31'd0, b}, 32'd1);
        check("R9 write raises discard", {31'd0, d}, 32'd1);
      end
    end

    // Probe sweep and read sweep
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        wr(2'd0, mk_tag(s, w + 1, s + w, 1'b1));
        cmd(3'd1, d, b);
        check("R4 probe hit index", slot_q, 32'(s * WAYS + w));
        check("R4 probe no discard", {31'd0, d}, 32'd0);
        wr(2'd0, 32'd0);
        cmd(3'd5, d, b);
        check("R12 read tag", tag_q, mk_tag(s, w + 1, s + w, 1'b1));
        check("R12 read data", data_q, mk_dat(s, w));
        check("R12 slot kept", slot_q, 32'(s * WAYS + w));
      end
    end

    // R5 identifier mismatch and page mismatch
    wr(2'd0, mk_tag(7, 1, 7 + 99, 1'b1)); cmd(3'd1, d, b);
    check("R5 id mismatch misses", slot_q, MISS);
    wr(2'd0, mk_tag(7, 9, 7, 1'b1)); cmd(3'd1, d, b);
    check("R5 page mismatch misses", slot_q, MISS);

    // R8 round robin on full sets
    wr(2'd0, mk_tag(5, 3, 0, 1'b1));
    cmd(3'd2, d, b); check("R8 rr first", slot_q, 32'd10);
    cmd(3'd2, d, b); check("R8 rr second", slot_q, 32'd11);
    cmd(3'd2, d, b); check("R8 rr wrap", slot_q, 32'd10);
    wr(2'd0, mk_tag(6, 3, 0, 1'b1));
    cmd(3'd2, d, b); check("R8 rr per set", slot_q, 32'd12);

    // R6 duplicate
    wr(2'd0, mk_tag(10, 85, 3, 1'b1));
    wr(2'd2, 32'd20); cmd(3'd3, d, b);
    wr(2'd2, 32'd21); cmd(3'd3, d, b);
    cmd(3'd1, d, b);
    check("R6 duplicate code", slot_q, DUP);

    // R10 write-quiet
    wr(2'd0, mk_tag(40, 119, 9, 1'b1));
    wr(2'd1, 32'h0BAD_F00D);
    wr(2'd2, 32'd80);
    cmd(3'd4, d, b);
    check("R10 no discard", {31'd0, d}, 32'd0);
    cmd(3'd1, d, b);
    check("R10 stored entry found", slot_q, 32'd80);

    // R9 invalidating write then R7 free way again
    wr(2'd0, mk_tag(40, 119, 9, 1'b0));
    cmd(3'd3, d, b);
    wr(2'd0, mk_tag(40, 119, 9, 1'b1));
    cmd(3'd1, d, b);
    check("R9 invalidated entry misses", slot_q, MISS);
    cmd(3'd2, d, b);
    check("R7 invalidated way is free", slot_q, 32'd80);

    // R11 discard only
    wr(2'd0, 32'h5555_0000); wr(2'd1, 32'h6666_0000); wr(2'd2, 32'd81);
    cmd(3'd6, d, b);
    check("R11 discard pulse", {31'd0, d}, 32'd1);
    check("R11 tag unchanged", tag_q, 32'h5555_0000);
    check("R11 data unchanged", data_q, 32'h6666_0000);
    check("R11 slot unchanged", slot_q, 32'd81);
    wr(2'd0, mk_tag(40, 2, 41, 1'b1)); cmd(3'd1, d, b);
    check("R11 storage unchanged", slot_q, 32'd81);

    // R13 reserved codes
    cmd(3'd7, d, b);
    check("R13 code7 no pulse", {31'd0, d}, 32'd0);
    check("R13 code7 slot", slot_q, 32'd81);
    check("R13 code7 tag", tag_q, mk_tag(40, 2, 41, 1'b1));
    cmd(3'd0, d, b);
    check("R13 code0 busy", {31'd0, b}, 32'd1);
    check("R13 code0 slot", slot_q, 32'd81);

    // R3 writes during busy ignored
    t_old = mk_tag(40, 2, 41, 1'b1);
    wr(2'd3, 32'd1);                  // probe accepted, busy now
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    reg_we = 1'b0;
    check("R3 busy clears", {31'd0, busy}, 32'd0);
    check("R3 tag write ignored", tag_q, t_old);
    check("R3 probe result kept", slot_q, 32'd81);
    wr(2'd3, 32'd1);
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd6;
    @(negedge clk);
    reg_we = 1'b0;
    check("R3 cmd in busy no pulse a", {31'd0, utlb_discard}, 32'd0);
    @(negedge clk);
    check("R3 cmd in busy no pulse b", {31'd0, utlb_discard}, 32'd0);
    check("R3 cmd in busy not busy", {31'd0, busy}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule